// File: doc/BRIEF.md
# Per-Channel PWM Edge Delay Bank

This block sits between a PWM modulator and the power stage. It shifts the timing of each of eight PWM bit streams by a programmable number of fast-clock cycles. The skew between channels can then be tuned to the output devices and the board layout. Each channel keeps a history of its input. Its output is taken from the history slot that the channel's active delay selects.

A plain register write port loads the settings, and a combinational read port returns them. The write port has an address, a data byte and a write strobe, and stands in for a serial control bus. There is one 8-bit delay register per channel and one extra offset register. The offset adds to the first channel only, and the sum saturates at the top of the range.

Settings may be rewritten while the streams run. A channel copies its new target into its active delay only when a rising edge arrives at its input. This keeps the switch from cutting a pulse in the middle of a period.

Top module: `pwm_skew_bank`

## Requirements
- R1: After reset, the delay registers for channels 1 to 8 read back 24, 0, 16, 16, 24, 8, 8 and 24. The offset register reads back 0.
- R2: A write to address 0x1B+k (k = 0..7) loads channel k+1's delay register, and a write to 0x23 loads the channel-1 offset. Each new value is visible on the read port from the next cycle.
- R3: Writes to any address below 0x1B or above 0x23 change no register. Reads of such addresses return 0.
- R4: With active delay D, a channel output equals its input as sampled D+1 clock edges earlier. For channels 2 to 8, D is that channel's delay register.
- R5: For channel 1, D is the delay register plus the offset register, clamped at 255. The delay register itself keeps its raw value.
- R6: A channel loads a new active delay only on a clock edge where its input is 1 and was 0 at the previous edge. At every other edge the active delay holds, even if the register was rewritten.
- R7: Delay 0 gives exactly one cycle of latency and delay 255 gives 256 cycles. Channels with equal delay stay aligned to the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast delay clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| pwm_in | input | 8 | PWM inputs, bit 0 is channel 1 |
| pwm_out | output | 8 | Delayed PWM outputs, bit 0 is channel 1 |

## Verification
The outputs are compared with a cycle-accurate reference on every cycle, under four input patterns:
- All-low inputs show that no output moves without a rising edge.
- Per-channel periodic PWM with distinct periods separates the channels from one another.
- Identical slow squares on all channels make any misalignment between channels visible.
- Pseudo-random bits produce frequent rising edges, which catch a delay switch taken on the wrong edge.

A sweep of the delay values, with an offset that varies alongside, covers the latency map. Saturating offset sums, the 0 and 255 extremes, and stray writes next to the window confirm the clamp, the range ends and the address decode.

// File: rtl/skew_pkg.sv
package skew_pkg;

   // Power-up delay per channel index (0-based); unknown channels start at zero.
   function automatic int unsigned boot_delay(input int unsigned ch);
      case (ch)
         0: return 24;
         1: return 0;
         2: return 16;
         3: return 16;
         4: return 24;
         5: return 8;
         6: return 8;
         7: return 24;
         default: return 0;
      endcase
   endfunction

   // Clamp helper for reset-time constants.
   function automatic int unsigned clamp_to(input int unsigned v, input int unsigned lim);
      return (v > lim) ? lim : v;
   endfunction

endpackage

// File: rtl/skew_cfg_regs.sv
module skew_cfg_regs
   import skew_pkg::*;
#(
   parameter int unsigned N_CH      = 8,
   parameter int unsigned DW        = 8,
   parameter int unsigned AW        = 8,
   parameter int unsigned BASE_ADDR = 27
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [AW-1:0]             wr_addr,
   input  logic [DW-1:0]             wr_data,
   input  logic [AW-1:0]             rd_addr,
   output logic [DW-1:0]             rd_data,
   output logic [N_CH-1:0][DW-1:0]   dly_q,
   output logic [DW-1:0]             ofs_q
);

   localparam logic [AW-1:0] A_OFS = AW'(BASE_ADDR + N_CH);

   // One delay register per channel, each with its own decode.
   for (genvar c = 0; c < N_CH; c++) begin : g_dly
      localparam logic [AW-1:0] A_ME  = AW'(BASE_ADDR + c);
      localparam logic [DW-1:0] RST_V = DW'(boot_delay(c));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            dly_q[c] <= RST_V;
         else if (wr_en && (wr_addr == A_ME))
            dly_q[c] <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ofs_q <= '0;
      else if (wr_en && (wr_addr == A_OFS))
         ofs_q <= wr_data;
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < int'(N_CH); i++) begin
         if (rd_addr == AW'(BASE_ADDR + i))
            rd_data = dly_q[i];
      end
      if (rd_addr == A_OFS)
         rd_data = ofs_q;
   end

endmodule

// File: rtl/skew_lane.sv
module skew_lane #(
   parameter int unsigned DW      = 8,
   parameter int unsigned RST_DLY = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          din,
   input  logic [DW-1:0] tgt,
   output logic          dout,
   output logic [DW-1:0] act
);

   localparam int unsigned DEPTH = 1 << DW;

   // hist[k] holds the input sampled k+1 edges ago (k = 0 is the newest).
   logic [DEPTH-1:0] hist;
   logic             rise;

   assign rise = din & ~hist[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist <= '0;
         act  <= DW'(RST_DLY);
      end else begin
         hist <= {hist[DEPTH-2:0], din};
         if (rise)
            act <= tgt;
      end
   end

   assign dout = hist[act];

endmodule

// File: rtl/pwm_skew_bank.sv
module pwm_skew_bank
   import skew_pkg::*;
#(
   parameter int unsigned N_CH      = 8,
   parameter int unsigned DW        = 8,
   parameter int unsigned AW        = 8,
   parameter int unsigned BASE_ADDR = 27
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [AW-1:0]   wr_addr,
   input  logic [DW-1:0]   wr_data,
   input  logic [AW-1:0]   rd_addr,
   output logic [DW-1:0]   rd_data,
   input  logic [N_CH-1:0] pwm_in,
   output logic [N_CH-1:0] pwm_out
);

   localparam int unsigned DMAX = (1 << DW) - 1;

   if (DW < 2 || DW > 10) begin : g_bad_dw
      $error("pwm_skew_bank: DW must lie in 2..10");
   end
   if (N_CH < 1 || (BASE_ADDR + N_CH) >= (1 << AW)) begin : g_bad_map
      $error("pwm_skew_bank: register window does not fit the address space");
   end

   logic [N_CH-1:0][DW-1:0] dly_q;
   logic [DW-1:0]           ofs_q;
   logic [N_CH-1:0][DW-1:0] tgt;
   logic [N_CH-1:0][DW-1:0] act_q;

   skew_cfg_regs #(
      .N_CH(N_CH), .DW(DW), .AW(AW), .BASE_ADDR(BASE_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dly_q(dly_q), .ofs_q(ofs_q)
   );

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      if (c == 0) begin : g_offset
         // First channel: delay plus absolute offset, clamped.
         localparam int unsigned RST0 = clamp_to(boot_delay(0), DMAX);
         logic [DW:0] sum;
         assign sum    = {1'b0, dly_q[0]} + {1'b0, ofs_q};
         assign tgt[0] = sum[DW] ? {DW{1'b1}} : sum[DW-1:0];
         skew_lane #(.DW(DW), .RST_DLY(RST0)) u_lane (
            .clk(clk), .rst_n(rst_n), .din(pwm_in[0]), .tgt(tgt[0]),
            .dout(pwm_out[0]), .act(act_q[0])
         );
      end else begin : g_plain
         localparam int unsigned RSTC = clamp_to(boot_delay(c), DMAX);
         assign tgt[c] = dly_q[c];
         skew_lane #(.DW(DW), .RST_DLY(RSTC)) u_lane (
            .clk(clk), .rst_n(rst_n), .din(pwm_in[c]), .tgt(tgt[c]),
            .dout(pwm_out[c]), .act(act_q[c])
         );
      end
   end

endmodule

// File: rtl/skew_bank_chk.sv
module skew_bank_chk #(
   parameter int unsigned N_CH      = 8,
   parameter int unsigned DW        = 8,
   parameter int unsigned AW        = 8,
   parameter int unsigned BASE_ADDR = 27
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    wr_en,
   input logic [AW-1:0]           wr_addr,
   input logic [DW-1:0]           wr_data,
   input logic [N_CH-1:0]         pwm_in,
   input logic [N_CH-1:0]         pwm_out,
   input logic [N_CH-1:0][DW-1:0] dly_q,
   input logic [DW-1:0]           ofs_q,
   input logic [N_CH-1:0][DW-1:0] act_q
);

   localparam logic [AW-1:0] A_LO  = AW'(BASE_ADDR);
   localparam logic [AW-1:0] A_OFS = AW'(BASE_ADDR + N_CH);
   localparam logic [DW:0]   TOP   = {1'b0, {DW{1'b1}}};

   logic [N_CH-1:0] prev_in;
   logic            armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_in <= '0;
         armed   <= 1'b0;
      end else begin
         prev_in <= pwm_in;
         armed   <= 1'b1;
      end
   end

   // R3: writes outside the window leave every register untouched
   a_r3_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_addr < A_LO || wr_addr > A_OFS)) |=> ($stable(dly_q) && $stable(ofs_q)));

   // R2: offset write lands
   a_r2_ofs_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_OFS) |=> (ofs_q == $past(wr_data)));

   logic [DW:0] sum_now;
   assign sum_now = {1'b0, dly_q[0]} + {1'b0, ofs_q};

   // R5: channel 1 picks up the clamped sum on its rising edge
   a_r5_clamped_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_in[0] && !prev_in[0]) |=>
         (act_q[0] == (($past(sum_now) > TOP) ? {DW{1'b1}} : $past(sum_now[DW-1:0]))));

   for (genvar c = 0; c < N_CH; c++) begin : g_a
      // R2: delay write lands in its own channel
      a_r2_dly_write: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_addr == AW'(BASE_ADDR + c)) |=> (dly_q[c] == $past(wr_data)));

      // R6: active delay holds except after an input rising edge
      a_r6_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
         !(pwm_in[c] && !prev_in[c]) |=> $stable(act_q[c]));

      // R7: zero delay is one cycle of latency
      a_r7_zero_latency: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && act_q[c] == '0) |-> (pwm_out[c] == $past(pwm_in[c])));
   end

endmodule

bind pwm_skew_bank skew_bank_chk #(
   .N_CH(N_CH), .DW(DW), .AW(AW), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
   .pwm_in(pwm_in), .pwm_out(pwm_out), .dly_q(dly_q), .ofs_q(ofs_q), .act_q(act_q)
);

// File: tb/sim_pwm_skew_bank.sv
module sim_pwm_skew_bank;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic [7:0] pwm_in = '0;
   logic [7:0] pwm_out;

   always #4 clk = ~clk;   // 125 MHz

   pwm_skew_bank u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pwm_in(pwm_in), .pwm_out(pwm_out)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   int         regs_m [0:8];
   int         act_m  [0:7];
   logic [7:0] ih     [0:511];
   logic [7:0] prev_m = '0;
   int         cyc = 0;
   int         dflt [0:7] = '{24, 0, 16, 16, 24, 8, 8, 24};

   function automatic int tgt_m(input int c);
      int s;
      if (c != 0) return regs_m[c];
      s = regs_m[0] + regs_m[8];
      return (s > 255) ? 255 : s;
   endfunction

   initial for (int i = 0; i < 512; i++) ih[i] = '0;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int c = 0; c < 8; c++) begin regs_m[c] = dflt[c]; act_m[c] = dflt[c]; end
         regs_m[8] = 0;
         prev_m = '0;
         cyc = 0;
      end else begin
         cyc++;
         ih[cyc & 511] = pwm_in;
         for (int c = 0; c < 8; c++)
            if (pwm_in[c] && !prev_m[c]) act_m[c] = tgt_m(c);
         prev_m = pwm_in;
         if (wr_en && wr_addr >= 8'h1B && wr_addr <= 8'h23)
            regs_m[wr_addr - 8'h1B] = wr_data;
      end
   end

   // ---------------- continuous output check ----------------
   bit    live = 0;
   string ltag = "R4";

   initial forever begin
      @(negedge clk);
      if (live && rst_n)
         for (int c = 0; c < 8; c++)
            chk(ltag, pwm_out[c], ih[(cyc - act_m[c]) & 511][c]);
   end

   // ---------------- stimulus patterns ----------------
   int   mode = 0;   // 0 low, 1 per-channel PWM, 2 pseudo-random, 3 common square
   int   pcnt = 0;
   logic [15:0] lfsr = 16'hACE1;

   initial forever begin
      logic [7:0] v;
      @(negedge clk);
      pcnt++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v = '0;
      for (int c = 0; c < 8; c++) begin
         case (mode)
            1: v[c] = ((pcnt % (20 + 7 * c)) < (5 + 3 * c));
            2: v[c] = lfsr[c] ^ lfsr[c + 8];
            3: v[c] = ((pcnt % 64) < 32);
            default: v[c] = 1'b0;
         endcase
      end
      pwm_in <= v;
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [7:0] a, input int exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      chk(req, rd_data, exp);
   endtask

   task automatic dwell(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(8 * 190000);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   // ---------------- main sequence ----------------
   initial begin
      dwell(3);
      // R1: defaults during and after reset
      #1;
      chk("R1 out in reset", pwm_out, 0);
      for (int c = 0; c < 8; c++) rd_chk("R1", 8'(8'h1B + c), dflt[c]);
      rd_chk("R1 offset", 8'h23, 0);
      @(negedge clk); rst_n = 1'b1;
      for (int c = 0; c < 8; c++) rd_chk("R1", 8'(8'h1B + c), dflt[c]);
      rd_chk("R3 read below", 8'h1A, 0);
      rd_chk("R3 read above", 8'h24, 0);

      // R4: default delays under periodic and common squares
      live = 1; ltag = "R4";
      mode = 1; dwell(400);
      mode = 3; ltag = "R7 align"; dwell(300);

      // R2: rewrite and read back
      ltag = "R2";
      for (int c = 0; c < 8; c++) wr(8'(8'h1B + c), 8'(5 * c + 3));
      wr(8'h23, 8'd7);
      for (int c = 0; c < 8; c++) rd_chk("R2", 8'(8'h1B + c), 5 * c + 3);
      rd_chk("R2 offset", 8'h23, 7);
      dwell(300);

      // R6: live rewrites under dense random edges and with long-high periods
      ltag = "R6"; mode = 2;
      for (int k = 0; k < 40; k++) begin
         wr(8'(8'h1B + (k % 8)), 8'((k * 53) & 255));
         dwell(11);
      end
      mode = 1;
      for (int k = 0; k < 16; k++) begin
         wr(8'(8'h1B + (k % 8)), 8'((k * 29 + 60) & 255));
         dwell(7);
      end
      dwell(300);

      // R3: stray writes
      ltag = "R3";
      wr(8'h1A, 8'hFF); wr(8'h24, 8'hFF); wr(8'h00, 8'hAA); wr(8'hFF, 8'h55);
      for (int c = 0; c < 9; c++) rd_chk("R3", 8'(8'h1B + c), regs_m[c]);
      rd_chk("R3 read far", 8'hFF, 0);
      dwell(300);

      // R5: saturating offset
      ltag = "R5"; mode = 2;
      wr(8'h1B, 8'd200); wr(8'h23, 8'd100);
      rd_chk("R5 raw", 8'h1B, 200);
      dwell(300);
      wr(8'h1B, 8'd255); wr(8'h23, 8'd255);
      dwell(300);
      wr(8'h1B, 8'd100); wr(8'h23, 8'd155);
      dwell(300);

      // R7: extremes
      ltag = "R7 zero"; mode = 3;
      for (int c = 0; c < 8; c++) wr(8'(8'h1B + c), 8'd0);
      wr(8'h23, 8'd0);
      dwell(200);
      ltag = "R7 max"; mode = 2;
      for (int c = 0; c < 8; c++) wr(8'(8'h1B + c), 8'd255);
      dwell(600);

      // R4: sweep of delay values with a varying offset
      ltag = "R4 sweep";
      for (int d = 0; d < 256; d += 3) begin
         mode = (d % 2) ? 1 : 2;
         for (int c = 0; c < 8; c++) wr(8'(8'h1B + c), 8'((d + 37 * c) & 255));
         wr(8'h23, 8'(d / 2));
         dwell(270);
      end

      live = 0;
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule